// File: doc/BRIEF.md
# Row-Structured Reconfigurable Functional Unit Array

This block is a small coarse-grained compute array that evaluates one mapped custom instruction for a host pipeline. It has five rows of functional units (FUs), each with a configurable number of columns. Every FU applies one configured integer operation, such as a logical operation, add, subtract, shift or compare, to two operands. Each operand is picked by its own select field. The candidates are the external operand slots of the FU's own row, any FU result in the row above, a fixed row-skipping link, a link from the left neighbour in the same row, or zero.

The rows do not get the same share of external operands. The first row gets seven slots, rows two to four get two each, and the last row gets one. Fixed long links carry the rightmost FU result of a source row to a later row. A configuration store holds several complete contexts: per-FU words plus one global word. The global word sets the evaluation depth, the two result taps and the program-counter source. A context index is latched when an operation starts, so any other context can be rewritten while the array runs.

The datapath is combinational from the top row to the bottom row. A start/done handshake models the variable delay: done pulses once the configured number of rows has elapsed. Results and the next program-counter value are captured in the done cycle and held until the next completion.

Top module: `rfu_top`

## Requirements
- R1: External slot g of `ext_in` (bits g*W+W-1:g*W) is assigned by row: slots 0..6 to row 0, 7..8 to row 1, 9..10 to row 2, 11..12 to row 3 and 13 to row 4. A select of kind 0 with index i picks slot i of the FU's own row, and an index at or above that row's slot count gives zero.
- R2: Each FU config word is {sel_b[13:9], sel_a[8:4], op[3:0]}, and each select is {kind[4:3], idx[2:0]}. Kind 1 picks FU idx of the row above, which gives zero in row 0 or when idx >= NCOL. Kind 3 gives zero. FU index n is row n/NCOL, column n%NCOL.
- R3: Kind 2 picks a link. Idx 0 is the long link from row 0's rightmost FU into rows 2, 3 and 4. Idx 1 is the link from row 1's rightmost FU into row 3. Idx 2 is the left neighbour's result in rows 2 and 3 for columns > 0. Every other case gives zero.
- R4: Op codes are 0 AND, 1 OR, 2 XOR, 3 NOR, 4 ADD, 5 SUB, 6 shift left, 7 logical shift right, 8 arithmetic shift right, 9 signed less-than, 10 unsigned less-than and 11 pass a. Shift amounts use the low log2(W) bits of b. Compares return 1 or 0. Codes 12..15 give zero.
- R5: Config address NFU holds the global word {out1[18:14], out0[13:9], pc_src[8:4], branch[3], depth[2:0]}. `done` pulses for one cycle exactly depth clock edges after the edge that accepts `start`. A depth of 0 counts as 1, and a depth above 5 counts as 5.
- R6: `start` is accepted only when `busy` is low. Results and `pc_out` change only in the cycle `done` is high, and they hold otherwise.
- R7: Result slot k of `res_out` carries the FU selected by out_k. An index >= NFU gives zero.
- R8: When branch is 1, `pc_out` is the result of FU pc_src (zero if the index is out of range). Otherwise it is `pc_in` + 4.
- R9: The context index on `ctx_sel` is latched when `start` is accepted. Changing `ctx_sel` while busy has no effect on the run.
- R10: A write (`cfg_we`, `cfg_ctx`, `cfg_addr`, `cfg_data`) takes effect at the next edge. Writing a context other than the running one leaves that run's results unchanged, and the written values are used by later runs of that context.
- R11: After reset, `busy`, `done`, `res_out` and `pc_out` are zero, and every context word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin evaluation of the selected context |
| ctx_sel | input | CTXW | Context to run, sampled at start |
| ext_in | input | 14*W | External operand slots, row-assigned |
| pc_in | input | W | Current program counter |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctx | input | CTXW | Context index of the write |
| cfg_addr | input | AW | Word index: FU 0..NFU-1 or global at NFU |
| cfg_data | input | CFG_W | Configuration word |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_out | output | NOUT*W | Captured result taps |
| pc_out | output | W | Captured next program counter |

## Verification
The assertions assume that `ext_in` and `pc_in` stay stable while `busy` is high. They also assume that software does not rewrite the context that is currently running, because the captured result depends on the values present during the final busy cycle. The bench changes operand slots only between runs. Its in-flight writes target other contexts, while `ctx_sel` is deliberately moved during a run to show that the latched index is the one that counts.

// File: rtl/rfu_pkg.sv
package rfu_pkg;

    localparam int NROW       = 5;
    localparam int MAX_ROW_IN = 7;
    localparam int TOTAL_IN   = 14;
    localparam int NLINK      = 3;

    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_NOR  = 4'd3,
        OP_ADD  = 4'd4,
        OP_SUB  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_SRA  = 4'd8,
        OP_SLT  = 4'd9,
        OP_SLTU = 4'd10,
        OP_PASS = 4'd11
    } fu_op_e;

    localparam logic [1:0] K_EXT   = 2'd0;
    localparam logic [1:0] K_ABOVE = 2'd1;
    localparam logic [1:0] K_LINK  = 2'd2;
    localparam logic [1:0] K_ZERO  = 2'd3;

    typedef struct packed {
        logic [1:0] kind;
        logic [2:0] idx;
    } opnd_sel_t;

    typedef struct packed {
        opnd_sel_t  sel_b;
        opnd_sel_t  sel_a;
        logic [3:0] op;
    } fu_cfg_t;

    function automatic int row_inputs(input int r);
        case (r)
            0:       return 7;
            1, 2, 3: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int row_offset(input int r);
        int acc;
        acc = 0;
        for (int i = 0; i < r; i++) acc += row_inputs(i);
        return acc;
    endfunction

    // source row of long link k into row r, or -1 when absent
    function automatic int skip_src(input int r, input int k);
        if (k == 0 && r >= 2) return 0;
        if (k == 1 && r == 3) return 1;
        return -1;
    endfunction

    function automatic bit has_left(input int r);
        return (r == 2) || (r == 3);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfu_fu.sv
module rfu_fu
    import rfu_pkg::*;
#(
    parameter int W    = 32,
    parameter int NCOL = 4
) (
    input  fu_cfg_t                 cfg,
    input  logic [MAX_ROW_IN*W-1:0] ext_c,
    input  logic [NCOL*W-1:0]       above_c,
    input  logic [NLINK*W-1:0]      link_c,
    output logic [W-1:0]            y
);
    localparam int SHW = $clog2(W);

    function automatic logic [W-1:0] pick(
        input opnd_sel_t                 s,
        input logic [MAX_ROW_IN*W-1:0]   ev,
        input logic [NCOL*W-1:0]         av,
        input logic [NLINK*W-1:0]        lv
    );
        logic [W-1:0] v;
        v = '0;
        case (s.kind)
            K_EXT:   if (int'(s.idx) < MAX_ROW_IN) v = ev[int'(s.idx)*W +: W];
            K_ABOVE: if (int'(s.idx) < NCOL)       v = av[int'(s.idx)*W +: W];
            K_LINK:  if (int'(s.idx) < NLINK)      v = lv[int'(s.idx)*W +: W];
            default: v = '0;
        endcase
        return v;
    endfunction

    logic [W-1:0]        a_d, b_d;
    logic signed [W-1:0] a_s, b_s;
    logic [SHW-1:0]      sh_d;

    always_comb begin
        a_d  = pick(cfg.sel_a, ext_c, above_c, link_c);
        b_d  = pick(cfg.sel_b, ext_c, above_c, link_c);
        a_s  = a_d;
        b_s  = b_d;
        sh_d = b_d[SHW-1:0];
        case (cfg.op)
            OP_AND:  y = a_d & b_d;
            OP_OR:   y = a_d | b_d;
            OP_XOR:  y = a_d ^ b_d;
            OP_NOR:  y = ~(a_d | b_d);
            OP_ADD:  y = a_d + b_d;
            OP_SUB:  y = a_d - b_d;
            OP_SLL:  y = a_d << sh_d;
            OP_SRL:  y = a_d >> sh_d;
            OP_SRA:  y = a_s >>> sh_d;
            OP_SLT:  y = {{(W-1){1'b0}}, (a_s < b_s)};
            OP_SLTU: y = {{(W-1){1'b0}}, (a_d < b_d)};
            OP_PASS: y = a_d;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/rfu_array.sv
module rfu_array
    import rfu_pkg::*;
#(
    parameter int W    = 32,
    parameter int NCOL = 4,
    parameter int FU_W = $bits(fu_cfg_t),
    parameter int NFU  = NROW * NCOL
) (
    input  logic [TOTAL_IN*W-1:0] ext_in,
    input  logic [NFU*FU_W-1:0]   fu_cfg_flat,
    output logic [NFU*W-1:0]      fu_res_flat
);
    logic [W-1:0] res [NFU];

    for (genvar r = 0; r < NROW; r++) begin : g_row
        for (genvar c = 0; c < NCOL; c++) begin : g_col
            localparam int ID = r * NCOL + c;
            logic [MAX_ROW_IN*W-1:0] ext_c;
            logic [NCOL*W-1:0]       above_c;
            logic [NLINK*W-1:0]      link_c;

            for (genvar s = 0; s < MAX_ROW_IN; s++) begin : g_ext
                if (s < row_inputs(r)) begin : g_on
                    assign ext_c[s*W +: W] = ext_in[(row_offset(r) + s)*W +: W];
                end else begin : g_off
                    assign ext_c[s*W +: W] = '0;
                end
            end

            for (genvar j = 0; j < NCOL; j++) begin : g_above
                if (r > 0) begin : g_on
                    assign above_c[j*W +: W] = res[(r-1)*NCOL + j];
                end else begin : g_off
                    assign above_c[j*W +: W] = '0;
                end
            end

            for (genvar k = 0; k < 2; k++) begin : g_skip
                if (skip_src(r, k) >= 0) begin : g_on
                    assign link_c[k*W +: W] = res[skip_src(r, k)*NCOL + NCOL - 1];
                end else begin : g_off
                    assign link_c[k*W +: W] = '0;
                end
            end

            if (has_left(r) && c > 0) begin : g_left
                assign link_c[2*W +: W] = res[ID - 1];
            end else begin : g_noleft
                assign link_c[2*W +: W] = '0;
            end

            rfu_fu #(.W(W), .NCOL(NCOL)) u_fu (
                .cfg     (fu_cfg_t'(fu_cfg_flat[ID*FU_W +: FU_W])),
                .ext_c   (ext_c),
                .above_c (above_c),
                .link_c  (link_c),
                .y       (res[ID])
            );

            assign fu_res_flat[ID*W +: W] = res[ID];
        end
    end

endmodule

// File: rtl/rfu_cfg_store.sv
module rfu_cfg_store #(
    parameter int NCTX  = 4,
    parameter int NWORD = 21,
    parameter int CFG_W = 19,
    parameter int CTXW  = $clog2(NCTX),
    parameter int AW    = $clog2(NWORD)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CTXW-1:0]        wr_ctx,
    input  logic [AW-1:0]          wr_addr,
    input  logic [CFG_W-1:0]       wr_data,
    input  logic [CTXW-1:0]        rd_ctx,
    output logic [NWORD*CFG_W-1:0] rd_words
);
    logic [CFG_W-1:0] mem_d [NCTX][NWORD];
    logic [CFG_W-1:0] mem_q [NCTX][NWORD];

    always_comb begin
        mem_d = mem_q;
        if (wr_en && int'(wr_ctx) < NCTX && int'(wr_addr) < NWORD)
            mem_d[wr_ctx][wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCTX; i++)
                for (int j = 0; j < NWORD; j++)
                    mem_q[i][j] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        for (int j = 0; j < NWORD; j++)
            rd_words[j*CFG_W +: CFG_W] = mem_q[rd_ctx][j];
    end

    // R10: a write to another context leaves the read context's words alone
    p_inactive_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ctx != rd_ctx) |=>
            (rd_ctx != $past(rd_ctx)) || (rd_words == $past(rd_words)));

endmodule

// File: rtl/rfu_top.sv
module rfu_top
    import rfu_pkg::*;
#(
    parameter int W       = 32,
    parameter int NCOL    = 4,
    parameter int NCTX    = 4,
    parameter int NOUT    = 2,
    parameter int PC_STEP = 4,
    localparam int NFU    = NROW * NCOL,
    localparam int FU_W   = $bits(fu_cfg_t),
    localparam int IDXW   = $clog2(NFU + 1),
    localparam int DEPW   = $clog2(NROW + 1),
    localparam int GLB_W  = DEPW + 1 + IDXW * (NOUT + 1),
    localparam int CFG_W  = max2(FU_W, GLB_W),
    localparam int CTXW   = $clog2(NCTX),
    localparam int AW     = $clog2(NFU + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CTXW-1:0]       ctx_sel,
    input  logic [TOTAL_IN*W-1:0] ext_in,
    input  logic [W-1:0]          pc_in,
    input  logic                  cfg_we,
    input  logic [CTXW-1:0]       cfg_ctx,
    input  logic [AW-1:0]         cfg_addr,
    input  logic [CFG_W-1:0]      cfg_data,
    output logic                  busy,
    output logic                  done,
    output logic [NOUT*W-1:0]     res_out,
    output logic [W-1:0]          pc_out
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic [DEPW-1:0]   cnt;
        logic [CTXW-1:0]   ctx;
        logic [NOUT*W-1:0] res;
        logic [W-1:0]      pc;
    } state_t;

    state_t s_d, s_q;

    logic [(NFU+1)*CFG_W-1:0] rd_words;
    logic [NFU*FU_W-1:0]      fu_cfg_flat;
    logic [NFU*W-1:0]         fu_res_flat;
    logic [CFG_W-1:0]         glb;
    logic [NOUT*W-1:0]        res_sel;
    logic [W-1:0]             pc_sel;
    int                       dep_eff;

    rfu_cfg_store #(
        .NCTX(NCTX), .NWORD(NFU + 1), .CFG_W(CFG_W), .CTXW(CTXW), .AW(AW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_ctx   (cfg_ctx),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_data),
        .rd_ctx   (s_q.ctx),
        .rd_words (rd_words)
    );

    always_comb begin
        for (int i = 0; i < NFU; i++)
            fu_cfg_flat[i*FU_W +: FU_W] = rd_words[i*CFG_W +: FU_W];
    end

    rfu_array #(.W(W), .NCOL(NCOL), .FU_W(FU_W), .NFU(NFU)) u_array (
        .ext_in      (ext_in),
        .fu_cfg_flat (fu_cfg_flat),
        .fu_res_flat (fu_res_flat)
    );

    // global word decode: depth, branch flag, pc source, result taps
    always_comb begin
        logic [DEPW-1:0] dep_raw;
        logic [IDXW-1:0] tap;
        glb     = rd_words[NFU*CFG_W +: CFG_W];
        dep_raw = glb[DEPW-1:0];
        if (dep_raw == '0)              dep_eff = 1;
        else if (int'(dep_raw) > NROW)  dep_eff = NROW;
        else                            dep_eff = int'(dep_raw);

        for (int k = 0; k < NOUT; k++) begin
            tap = glb[DEPW + 1 + IDXW*(k+1) +: IDXW];
            if (int'(tap) < NFU) res_sel[k*W +: W] = fu_res_flat[int'(tap)*W +: W];
            else                 res_sel[k*W +: W] = '0;
        end

        tap = glb[DEPW + 1 +: IDXW];
        if (glb[DEPW])
            pc_sel = (int'(tap) < NFU) ? fu_res_flat[int'(tap)*W +: W] : '0;
        else
            pc_sel = pc_in + W'(PC_STEP);
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
                s_d.ctx  = ctx_sel;
            end
        end else if (int'(s_q.cnt) + 1 >= dep_eff) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            s_d.res  = res_sel;
            s_d.pc   = pc_sel;
        end else begin
            s_d.cnt  = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign res_out = s_q.res;
    assign pc_out  = s_q.pc;

    // R5: completion is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: completion only follows a busy cycle
    p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R6: busy and done never overlap
    p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R6: an idle start is always taken
    p_start_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R6: outputs move only on completion
    p_hold_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_out) && $stable(pc_out)));

    // R9: the latched context stays fixed during a run
    p_ctx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(s_q.ctx));

endmodule

// File: tb/tb_rfu_top.sv
module tb_rfu_top;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 32;
    localparam int NCOL  = 4;
    localparam int NCTX  = 4;
    localparam int NOUT  = 2;
    localparam int NFU   = 20;
    localparam int CFG_W = 19;
    localparam int NIN   = 14;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [1:0]        ctx_sel;
    logic [NIN*W-1:0]  ext_in;
    logic [W-1:0]      pc_in;
    logic              cfg_we;
    logic [1:0]        cfg_ctx;
    logic [4:0]        cfg_addr;
    logic [CFG_W-1:0]  cfg_data;
    logic              busy, done;
    logic [NOUT*W-1:0] res_out;
    logic [W-1:0]      pc_out;

    logic [W-1:0] ext [NIN];

    rfu_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctx_sel(ctx_sel),
        .ext_in(ext_in), .pc_in(pc_in), .cfg_we(cfg_we), .cfg_ctx(cfg_ctx),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .busy(busy), .done(done),
        .res_out(res_out), .pc_out(pc_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb for (int g = 0; g < NIN; g++) ext_in[g*W +: W] = ext[g];

    int    ntests = 0;
    int    nfail  = 0;
    string cur_tag = "R11";

    // reference model state
    logic [CFG_W-1:0] cfg_m [NCTX][NFU+1];
    logic [W-1:0]     mv [5][NCOL];
    logic             m_busy, m_done;
    int               m_cnt, m_ctx;
    logic [W-1:0]     m_res [NOUT];
    logic [W-1:0]     m_pc;

    function automatic int rcnt(int r);
        return (r == 0) ? 7 : (r == 4) ? 1 : 2;
    endfunction
    function automatic int roff(int r);
        return (r == 0) ? 0 : 7 + 2*(r-1);
    endfunction

    function automatic logic [W-1:0] m_opnd(logic [4:0] s, int r, int c);
        int k = int'(s[4:3]);
        int i = int'(s[2:0]);
        if (k == 0) return (i < rcnt(r)) ? ext[roff(r) + i] : '0;
        if (k == 1) return (r > 0 && i < NCOL) ? mv[r-1][i] : '0;
        if (k == 2) begin
            if (i == 0 && r >= 2) return mv[0][NCOL-1];
            if (i == 1 && r == 3) return mv[1][NCOL-1];
            if (i == 2 && (r == 2 || r == 3) && c > 0) return mv[r][c-1];
        end
        return '0;
    endfunction

    function automatic logic [W-1:0] m_alu(int op, logic [W-1:0] a, logic [W-1:0] b);
        int sh = int'(b[4:0]);
        case (op)
            0: return a & b;
            1: return a | b;
            2: return a ^ b;
            3: return ~(a | b);
            4: return a + b;
            5: return a - b;
            6: return a << sh;
            7: return a >> sh;
            8: return W'($signed(a) >>> sh);
            9: return ($signed(a) < $signed(b)) ? 1 : 0;
            10: return (a < b) ? 1 : 0;
            11: return a;
            default: return '0;
        endcase
    endfunction

    function automatic logic [W-1:0] m_tap(int idx);
        return (idx < NFU) ? mv[idx / NCOL][idx % NCOL] : '0;
    endfunction

    task automatic m_eval(int cx);
        logic [CFG_W-1:0] g;
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < NCOL; c++) begin
                logic [CFG_W-1:0] w = cfg_m[cx][r*NCOL + c];
                mv[r][c] = m_alu(int'(w[3:0]), m_opnd(w[8:4], r, c), m_opnd(w[13:9], r, c));
            end
        g = cfg_m[cx][NFU];
        m_res[0] = m_tap(int'(g[13:9]));
        m_res[1] = m_tap(int'(g[18:14]));
        m_pc = g[3] ? m_tap(int'(g[8:4])) : pc_in + 4;
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_ctx = 0;
            m_res[0] = '0; m_res[1] = '0; m_pc = '0;
            for (int i = 0; i < NCTX; i++)
                for (int j = 0; j <= NFU; j++) cfg_m[i][j] = '0;
        end else begin
            int d = int'(cfg_m[m_ctx][NFU][2:0]);
            if (d == 0) d = 1;
            if (d > 5) d = 5;
            m_done = 0;
            if (!m_busy) begin
                if (start) begin m_busy = 1; m_cnt = 0; m_ctx = int'(ctx_sel); end
            end else begin
                m_cnt++;
                if (m_cnt >= d) begin m_busy = 0; m_done = 1; m_eval(m_ctx); end
            end
            if (cfg_we) cfg_m[cfg_ctx][cfg_addr] = cfg_data;
        end
    endtask

    task automatic compare();
        logic [NOUT*W-1:0] er = {m_res[1], m_res[0]};
        ntests++;
        if (busy !== m_busy || done !== m_done || res_out !== er || pc_out !== m_pc) begin
            nfail++;
            $display("FAIL %s: busy/done/res/pc got %b/%b/%h/%h expected %b/%b/%h/%h",
                     cur_tag, busy, done, res_out, pc_out, m_busy, m_done, er, m_pc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        ntests++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [CFG_W-1:0] fuw(int op, int ka, int ia, int kb, int ib);
        return {5'd0, 2'(kb), 3'(ib), 2'(ka), 3'(ia), 4'(op)};
    endfunction
    function automatic logic [CFG_W-1:0] glw(int dep, int br, int pcs, int o0, int o1);
        return {5'(o1), 5'(o0), 5'(pcs), 1'(br), 3'(dep)};
    endfunction

    task automatic wr(int cx, int addr, logic [CFG_W-1:0] data);
        cfg_we = 1; cfg_ctx = 2'(cx); cfg_addr = 5'(addr); cfg_data = data;
        tick();
        cfg_we = 0;
    endtask

    task automatic run(int cx, bit hold);
        start = 1; ctx_sel = 2'(cx);
        tick();
        if (!hold) start = 0;
        for (int i = 0; i < 12 && !done; i++) tick();
        start = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        rst_n = 0; start = 0; ctx_sel = 0; pc_in = 32'h1000;
        cfg_we = 0; cfg_ctx = 0; cfg_addr = 0; cfg_data = '0;
        for (int g = 0; g < NIN; g++) ext[g] = 32'h100 + g;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R11 reset state
        chk("R11 busy", {31'd0, busy}, 0);
        chk("R11 done", {31'd0, done}, 0);
        chk("R11 res0", res_out[31:0], 0);
        chk("R11 pc", pc_out, 0);

        // R1 R2 R4 basic two-row chain in context 0
        cur_tag = "R1 R2 R4 chain";
        ext[0] = 100; ext[1] = 23; ext[2] = 50; ext[3] = 8;
        wr(0, 0, fuw(4, 0, 0, 0, 1));
        wr(0, 1, fuw(5, 0, 2, 0, 3));
        wr(0, 4, fuw(2, 1, 0, 1, 1));
        wr(0, NFU, glw(2, 0, 0, 4, 1));
        run(0, 0);
        chk("R2 above xor", res_out[31:0], 32'd123 ^ 32'd42);
        chk("R4 sub", res_out[63:32], 32'd42);
        chk("R8 pc step", pc_out, 32'h1004);

        // R3 R8 long links and left neighbour in context 1
        cur_tag = "R3 R8 links";
        ext[6] = 32'h11; ext[8] = 32'h200; ext[9] = 5; ext[13] = 32'h300;
        wr(1, 3, fuw(11, 0, 6, 3, 0));
        wr(1, 7, fuw(11, 0, 1, 3, 0));
        wr(1, 8, fuw(11, 2, 0, 3, 0));
        wr(1, 9, fuw(4, 2, 2, 0, 0));
        wr(1, 12, fuw(1, 2, 0, 2, 1));
        wr(1, 16, fuw(4, 2, 0, 0, 0));
        wr(1, NFU, glw(5, 1, 16, 9, 12));
        run(1, 0);
        chk("R3 left+ext", res_out[31:0], 32'h16);
        chk("R3 two links", res_out[63:32], 32'h211);
        chk("R8 branch pc", pc_out, 32'h311);

        // R4 every op code, R7 out-of-range tap in context 2
        ext[0] = 32'hF000_0035; ext[1] = 32'h0000_0024;
        wr(2, NFU, glw(1, 0, 0, 0, 31));
        for (int op = 0; op < 16; op++) begin
            cur_tag = $sformatf("R4 R7 op %0d", op);
            wr(2, 0, fuw(op, 0, 0, 0, 1));
            run(2, 0);
        end
        chk("R7 tap out of range", res_out[63:32], 0);
        chk("R4 sra", m_alu(8, 32'hF000_0035, 4), 32'hFF00_0003);

        // R1 R2 R3 R5 zero sources and depth clamps in context 3
        cur_tag = "R1 R2 R3 R5 zeros";
        for (int g = 0; g < NIN; g++) ext[g] = 32'hA5A5_0000 + g;
        wr(3, 4, fuw(1, 0, 5, 3, 0));
        wr(3, 5, fuw(11, 2, 2, 3, 0));
        wr(3, 1, fuw(11, 2, 0, 3, 0));
        wr(3, NFU, glw(0, 0, 0, 4, 5));
        run(3, 0);
        chk("R1 slot beyond row", res_out[31:0], 0);
        chk("R3 no left in row 1", res_out[63:32], 0);
        wr(3, NFU, glw(7, 0, 0, 1, 21));
        cur_tag = "R5 R7 depth clamp";
        run(3, 0);
        chk("R3 no link into row 0", res_out[31:0], 0);

        // R6 start held while busy
        cur_tag = "R6 start held";
        for (int g = 0; g < NIN; g++) ext[g] = 0;
        ext[6] = 32'h11; ext[8] = 32'h200; ext[9] = 5; ext[13] = 32'h300;
        run(1, 1);
        chk("R6 held start result", res_out[31:0], 32'h16);
        tick();
        chk("R6 idle after done", {31'd0, busy}, 0);

        // R9 R10 ctx change and inactive writes during a run
        cur_tag = "R9 R10 in-flight";
        start = 1; ctx_sel = 1;
        tick();
        start = 0; ctx_sel = 2;
        wr(2, 0, fuw(5, 0, 0, 0, 1));
        wr(0, NFU, glw(1, 1, 0, 0, 0));
        for (int i = 0; i < 12 && !done; i++) tick();
        chk("R9 latched ctx", res_out[31:0], 32'h16);
        chk("R10 unchanged run", pc_out, 32'h311);
        cur_tag = "R10 new config";
        run(2, 0);
        chk("R10 written ctx used", res_out[31:0], ext[0] - ext[1]);

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule